// File: doc/BRIEF.md
# Blocking write-back data cache controller

This block sits between a processor's load/store port and a main-memory port that moves one whole cache line per transaction. It accepts one access at a time, compares the address tag against the tags of the addressed set, and serves hits from its own line storage. On a miss it picks a victim line. If that line holds modified data, it first writes the line back to memory, then fetches the missing line, installs it, and finishes the original load or store. Stores allocate on a miss: the fetched line is installed first, and the store bytes are merged into it afterwards.

The organisation is chosen by the `WAYS` parameter: 1 gives a direct-mapped cache and 2 gives a two-way set-associative cache with one least-recently-used bit per set. Line size and set count are also parameters. Every access scenario has a fixed, exact latency, so the processor side can count on it. A store always costs one cycle more than the matching load, because the data write happens after the tag check. Evicting a dirty line adds a fixed write-back phase in front of the refill.

Top module: `cache_ctrl`

## Requirements
- R1: A load that hits raises `cpu_resp` exactly 2 cycles after the clock edge at which it was accepted (`cpu_req` and `cpu_ready` both high), and `cpu_rdata` carries the addressed word in that cycle.
- R2: A store that hits raises `cpu_resp` 3 cycles after acceptance. Byte i of the word (bits 8i+7 to 8i) is replaced when `cpu_be[i]` is 1 and keeps its old value otherwise, as later loads show.
- R3: A load that misses, where the victim line is invalid or clean, raises `cpu_resp` 6 cycles after acceptance and returns the word from the fetched line.
- R4: A store that misses, where the victim is invalid or clean, raises `cpu_resp` 7 cycles after acceptance. The line is fetched first and the masked bytes are merged into it afterwards.
- R5: A load that misses with a dirty victim raises `cpu_resp` 14 cycles after acceptance. Exactly one memory write happens during the access, to the victim's own line address, and it is issued before the line fetch.
- R6: A store that misses with a dirty victim raises `cpu_resp` 15 cycles after acceptance, with the same single write-back of the victim.
- R7: `cpu_ready` is high only while the controller is idle. It drops at acceptance and stays low until the cycle after the one-cycle `cpu_resp` pulse.
- R8: The address is split at default parameters as tag [31:8], set index [7:4] and word offset [3:2]. With 2 ways, an invalid way is filled before a valid one, with way 0 taken before way 1. When both ways are valid, the least recently used way of the set is replaced, where every hit and every refill counts as a use.
- R9: A line is marked dirty by a store hit or by the merge of a store miss, and marked clean when it is loaded. A line that was only loaded is evicted without any memory write.
- R10: While reset is asserted and after it is released, `cpu_ready` is 1, `cpu_resp` is 0 and `mem_req` is 0 until a request is accepted.
- R11: `mem_req` holds with a stable `mem_addr` and `mem_we` until `mem_ready`, and every `mem_addr` is line aligned. The latencies above assume that memory pulses `mem_rvalid` 3 cycles after it accepts a line read and 7 cycles after it accepts a line write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| cpu_ready | output | 1 | Controller idle and able to accept a request |
| cpu_resp | output | 1 | One-cycle pulse when the access completes |
| cpu_rdata | output | 32 | Load data, valid while cpu_resp is high |
| mem_req | output | 1 | Line transaction request |
| mem_we | output | 1 | 1 for a line write-back, 0 for a line fetch |
| mem_addr | output | ADDR_W | Line-aligned memory address |
| mem_wdata | output | LINE_WORDS*32 | Line being written back |
| mem_ready | input | 1 | Memory takes the request on this edge |
| mem_rvalid | input | 1 | Fetch data valid, or write acknowledged |
| mem_rdata | input | LINE_WORDS*32 | Fetched line |

## Verification
The assertions assume that memory pulses `mem_rvalid` only once per accepted transaction. They also assume that `cpu_req` matters only while `cpu_ready` is high, so a request is never counted twice. The behavioural memory in the bench keeps a single transaction in flight, holds `mem_ready` low while it is busy, and answers each transaction with exactly one pulse at the fixed latency. The processor driver raises a request only after seeing `cpu_ready` and drops it right after the acceptance edge, so every access follows the one-outstanding rule the checks rely on.

// File: rtl/cache_pkg.sv
package cache_pkg;

  localparam int WORD_W = 32;
  localparam int BE_W   = WORD_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TAG,
    ST_WB_REQ,
    ST_WB_WAIT,
    ST_FILL_REQ,
    ST_FILL_WAIT,
    ST_WRITE,
    ST_RESP
  } cc_state_e;

endpackage

// File: rtl/cache_store.sv
module cache_store #(
  parameter int WAYS   = 2,
  parameter int SETS   = 16,
  parameter int TAG_W  = 24,
  parameter int LINE_W = 128
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(SETS)-1:0]       rd_idx,
  output logic [WAYS-1:0][TAG_W-1:0]    rd_tag,
  output logic [WAYS-1:0]               rd_valid,
  output logic [WAYS-1:0]               rd_dirty,
  output logic [WAYS-1:0][LINE_W-1:0]   rd_line,
  input  logic                          wr_en,
  input  logic                          wr_way,
  input  logic [$clog2(SETS)-1:0]       wr_idx,
  input  logic [TAG_W-1:0]              wr_tag,
  input  logic [LINE_W-1:0]             wr_line,
  input  logic                          wr_dirty
);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] line_q [SETS];
    logic [SETS-1:0]   vld_q;
    logic [SETS-1:0]   drt_q;
    logic              sel;

    assign sel = wr_en && (wr_way == 1'(w));

    // tag and data storage: no reset, written only through the enable
    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[wr_idx]  <= wr_tag;
        line_q[wr_idx] <= wr_line;
      end
    end

    // state bits: reset so that every line starts invalid and clean
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
        drt_q <= '0;
      end else if (sel) begin
        vld_q[wr_idx] <= 1'b1;
        drt_q[wr_idx] <= wr_dirty;
      end
    end

    assign rd_tag[w]   = tag_q[rd_idx];
    assign rd_line[w]  = line_q[rd_idx];
    assign rd_valid[w] = vld_q[rd_idx];
    assign rd_dirty[w] = drt_q[rd_idx];
  end

endmodule

// File: rtl/cache_victim.sv
module cache_victim #(
  parameter int WAYS = 2,
  parameter int SETS = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(SETS)-1:0] idx,
  input  logic [WAYS-1:0]         valid_bits,
  input  logic                    upd_en,
  input  logic                    upd_way,
  output logic                    victim
);

  if (WAYS == 2) begin : g_lru
    // one bit per set naming the way to replace next
    logic [SETS-1:0] lru_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lru_q <= '0;
      end else if (upd_en) begin
        lru_q[idx] <= ~upd_way;
      end
    end

    always_comb begin
      if (!valid_bits[0])      victim = 1'b0;
      else if (!valid_bits[1]) victim = 1'b1;
      else                     victim = lru_q[idx];
    end
  end else begin : g_direct
    logic unused_victim_in;
    assign unused_victim_in = ^{clk, rst_n, idx, valid_bits, upd_en, upd_way};
    assign victim = 1'b0;
  end

endmodule

// File: rtl/cache_fsm.sv
module cache_fsm
  import cache_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_req,
  input  logic req_we,
  input  logic hit,
  input  logic vict_dirty,
  input  logic mem_ready,
  input  logic mem_rvalid,
  output logic cpu_ready,
  output logic cpu_resp,
  output logic accept,
  output logic st_tag,
  output logic fill_done,
  output logic do_write,
  output logic mem_req,
  output logic mem_we
);

  cc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (cpu_req) state_d = ST_TAG;
      ST_TAG: begin
        if (hit)             state_d = req_we ? ST_WRITE : ST_RESP;
        else if (vict_dirty) state_d = ST_WB_REQ;
        else                 state_d = ST_FILL_REQ;
      end
      ST_WB_REQ:    if (mem_ready)  state_d = ST_WB_WAIT;
      ST_WB_WAIT:   if (mem_rvalid) state_d = ST_FILL_REQ;
      ST_FILL_REQ:  if (mem_ready)  state_d = ST_FILL_WAIT;
      ST_FILL_WAIT: if (mem_rvalid) state_d = req_we ? ST_WRITE : ST_RESP;
      ST_WRITE:     state_d = ST_RESP;
      ST_RESP:      state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign cpu_ready = (state_q == ST_IDLE);
  assign cpu_resp  = (state_q == ST_RESP);
  assign accept    = cpu_ready && cpu_req;
  assign st_tag    = (state_q == ST_TAG);
  assign fill_done = (state_q == ST_FILL_WAIT) && mem_rvalid;
  assign do_write  = (state_q == ST_WRITE);
  assign mem_req   = (state_q == ST_WB_REQ) || (state_q == ST_FILL_REQ);
  assign mem_we    = (state_q == ST_WB_REQ);

  // write-back acknowledge is followed directly by the line fetch
  assert_wb_then_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WB_WAIT && mem_rvalid) |=> (mem_req && !mem_we));

  // the completion pulse returns the port to idle
  assert_resp_then_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_resp |=> (cpu_ready && !cpu_resp));

  // a completion never coincides with the idle state
  assert_resp_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_resp |-> !cpu_ready);

endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 16,
  parameter int WAYS       = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cpu_req,
  input  logic                         cpu_we,
  input  logic [ADDR_W-1:0]            cpu_addr,
  input  logic [WORD_W-1:0]            cpu_wdata,
  input  logic [BE_W-1:0]              cpu_be,
  output logic                         cpu_ready,
  output logic                         cpu_resp,
  output logic [WORD_W-1:0]            cpu_rdata,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [LINE_WORDS*WORD_W-1:0] mem_wdata,
  input  logic                         mem_ready,
  input  logic                         mem_rvalid,
  input  logic [LINE_WORDS*WORD_W-1:0] mem_rdata
);

  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int LO_W   = OFF_W + 2;
  localparam int TAG_W  = ADDR_W - IDX_W - LO_W;
  localparam int LINE_W = LINE_WORDS * WORD_W;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_meta, rst_sync} <= 2'b00;
    else        {rst_meta, rst_sync} <= {1'b1, rst_meta};
  end

  logic accept, st_tag, fill_done, do_write, hit, vict_dirty, vict_way;

  // captured request
  logic              r_we;
  logic [BE_W-1:0]   r_be;
  logic [WORD_W-1:0] r_wdata;
  logic [TAG_W-1:0]  r_tag;
  logic [IDX_W-1:0]  r_idx;
  logic [OFF_W-1:0]  r_off;
  logic              unused_byte_lane;

  assign unused_byte_lane = ^cpu_addr[1:0];

  always_ff @(posedge clk) begin
    if (accept) begin
      r_we    <= cpu_we;
      r_be    <= cpu_be;
      r_wdata <= cpu_wdata;
      r_tag   <= cpu_addr[ADDR_W-1 -: TAG_W];
      r_idx   <= cpu_addr[LO_W +: IDX_W];
      r_off   <= cpu_addr[2 +: OFF_W];
    end
  end

  // storage
  logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
  logic [WAYS-1:0]             rd_valid;
  logic [WAYS-1:0]             rd_dirty;
  logic [WAYS-1:0][LINE_W-1:0] rd_line;
  logic                        wr_en;
  logic [LINE_W-1:0]           wr_line;
  logic [LINE_W-1:0]           merged;
  logic                        r_way;

  cache_store #(
    .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_sync),
    .rd_idx   (r_idx),
    .rd_tag   (rd_tag),
    .rd_valid (rd_valid),
    .rd_dirty (rd_dirty),
    .rd_line  (rd_line),
    .wr_en    (wr_en),
    .wr_way   (r_way),
    .wr_idx   (r_idx),
    .wr_tag   (r_tag),
    .wr_line  (wr_line),
    .wr_dirty (do_write)
  );

  // tag compare
  logic [WAYS-1:0] hit_vec;
  logic            hit_way;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = rd_valid[w] && (rd_tag[w] == r_tag);
  end
  assign hit = |hit_vec;

  if (WAYS == 2) begin : g_hit2
    assign hit_way = hit_vec[1];
  end else begin : g_hit1
    assign hit_way = 1'b0;
  end

  // replacement
  logic upd_en, upd_way;
  assign upd_en  = (st_tag && hit) || fill_done;
  assign upd_way = fill_done ? r_way : hit_way;

  cache_victim #(.WAYS(WAYS), .SETS(SETS)) u_victim (
    .clk        (clk),
    .rst_n      (rst_sync),
    .idx        (r_idx),
    .valid_bits (rd_valid),
    .upd_en     (upd_en),
    .upd_way    (upd_way),
    .victim     (vict_way)
  );

  assign vict_dirty = rd_valid[vict_way] && rd_dirty[vict_way];

  always_ff @(posedge clk) begin
    if (st_tag) r_way <= hit ? hit_way : vict_way;
  end

  // control
  cache_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync),
    .cpu_req    (cpu_req),
    .req_we     (r_we),
    .hit        (hit),
    .vict_dirty (vict_dirty),
    .mem_ready  (mem_ready),
    .mem_rvalid (mem_rvalid),
    .cpu_ready  (cpu_ready),
    .cpu_resp   (cpu_resp),
    .accept     (accept),
    .st_tag     (st_tag),
    .fill_done  (fill_done),
    .do_write   (do_write),
    .mem_req    (mem_req),
    .mem_we     (mem_we)
  );

  // store merge into the selected line
  always_comb begin
    merged = rd_line[r_way];
    for (int b = 0; b < BE_W; b++) begin
      if (r_be[b]) merged[r_off*WORD_W + b*8 +: 8] = r_wdata[b*8 +: 8];
    end
  end

  assign wr_en   = fill_done || do_write;
  assign wr_line = fill_done ? mem_rdata : merged;

  // memory side
  assign mem_wdata = rd_line[r_way];
  assign mem_addr  = mem_we ? {rd_tag[r_way], r_idx, {LO_W{1'b0}}}
                            : {r_tag,         r_idx, {LO_W{1'b0}}};

  // load data
  logic [WORD_W-1:0] rdata_q;
  logic [LINE_W-1:0] hit_line;
  assign hit_line = rd_line[hit_way];

  always_ff @(posedge clk) begin
    if (st_tag && hit && !r_we) rdata_q <= hit_line[r_off*WORD_W +: WORD_W];
    else if (fill_done)         rdata_q <= mem_rdata[r_off*WORD_W +: WORD_W];
  end
  assign cpu_rdata = rdata_q;

  // memory request held steady until taken
  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_sync)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // line-aligned memory addresses
  assert_mem_aligned_R11: assert property (@(posedge clk) disable iff (!rst_sync)
    mem_req |-> (mem_addr[LO_W-1:0] == '0));

endmodule

// File: tb/sim_cache_ctrl.sv
module sim_cache_ctrl;

  localparam int RD_LAT = 3;
  localparam int WR_LAT = 7;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cpu_req, cpu_we;
  logic [31:0]  cpu_addr, cpu_wdata;
  logic [3:0]   cpu_be;
  logic         cpu_ready, cpu_resp;
  logic [31:0]  cpu_rdata;
  logic         mem_req, mem_we, mem_ready, mem_rvalid;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata, mem_rdata;

  always #4 clk = ~clk;

  cache_ctrl #(.ADDR_W(32), .LINE_WORDS(4), .SETS(16), .WAYS(2)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
    .cpu_ready(cpu_ready), .cpu_resp(cpu_resp), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // initial contents of memory, as a function of the word address
  function automatic logic [31:0] init_word(input logic [31:0] a);
    return {a[15:0], ~a[17:2]} ^ 32'h3c5a_96e1;
  endfunction

  // behavioural line memory
  logic [127:0] dram [logic [31:0]];
  logic [31:0]  wb_q [$];
  int           m_cnt = 0;

  function automatic logic [127:0] get_line(input logic [31:0] la);
    logic [127:0] l;
    if (dram.exists(la)) return dram[la];
    for (int w = 0; w < 4; w++) l[w*32 +: 32] = init_word(la + 32'(w*4));
    return l;
  endfunction

  assign mem_ready  = (m_cnt == 0);
  assign mem_rvalid = (m_cnt == 1);

  always @(posedge clk) begin
    if (m_cnt != 0) m_cnt <= m_cnt - 1;
    if (mem_req && mem_ready) begin
      chk(mem_addr[3:0] == 4'h0, "R11", mem_addr, {mem_addr[31:4], 4'h0});
      if (mem_we) begin
        dram[mem_addr] = mem_wdata;
        wb_q.push_back(mem_addr);
        m_cnt <= WR_LAT;
      end else begin
        mem_rdata <= get_line(mem_addr);
        m_cnt <= RD_LAT;
      end
    end
  end

  // golden word image of memory as the processor sees it
  logic [31:0] gold [logic [31:0]];

  function automatic logic [31:0] gold_read(input logic [31:0] a);
    logic [31:0] wa = {a[31:2], 2'b00};
    if (gold.exists(wa)) return gold[wa];
    return init_word(wa);
  endfunction

  task automatic gold_write(input logic [31:0] a, input logic [31:0] d,
                            input logic [3:0] be);
    logic [31:0] v = gold_read(a);
    for (int b = 0; b < 4; b++) if (be[b]) v[b*8 +: 8] = d[b*8 +: 8];
    gold[{a[31:2], 2'b00}] = v;
  endtask

  // reference cache state
  logic [23:0] ref_tag [2][16];
  bit          ref_v   [2][16];
  bit          ref_d   [2][16];
  bit          ref_lru [16];

  task automatic access(input bit we, input logic [31:0] a,
                        input logic [31:0] wd, input logic [3:0] be);
    int          idx, hitw, way, lat;
    bit          exp_wb;
    logic [31:0] wb_addr, exp_d;
    string       rq;
    idx = int'(a[7:4]);
    hitw = -1;
    exp_wb = 0;
    wb_addr = '0;
    for (int w = 0; w < 2; w++)
      if (ref_v[w][idx] && ref_tag[w][idx] == a[31:8]) hitw = w;
    if (hitw >= 0) begin
      way = hitw;
      lat = we ? 3 : 2;
    end else begin
      if (!ref_v[0][idx])      way = 0;
      else if (!ref_v[1][idx]) way = 1;
      else                     way = int'(ref_lru[idx]);
      if (ref_v[way][idx] && ref_d[way][idx]) begin
        exp_wb = 1;
        wb_addr = {ref_tag[way][idx], a[7:4], 4'h0};
      end
      lat = exp_wb ? (we ? 15 : 14) : (we ? 7 : 6);
      ref_tag[way][idx] = a[31:8];
      ref_v[way][idx] = 1;
      ref_d[way][idx] = 0;
    end
    ref_lru[idx] = (way == 0);
    if (we) begin
      ref_d[way][idx] = 1;
      gold_write(a, wd, be);
    end
    exp_d = gold_read(a);
    case (lat)
      2: rq = "R1";
      3: rq = "R2";
      6: rq = "R3";
      7: rq = "R4";
      14: rq = "R5";
      default: rq = "R6";
    endcase
    wb_q.delete();
    @(negedge clk);
    chk(cpu_ready == 1'b1, "R7", 32'(cpu_ready), 32'd1);
    cpu_req = 1'b1;
    cpu_we = we;
    cpu_addr = a;
    cpu_wdata = wd;
    cpu_be = be;
    for (int n = 1; n <= lat + 1; n++) begin
      @(negedge clk);
      if (n == 1) begin
        cpu_req = 1'b0;
        cpu_we = 1'b0;
      end
      chk(cpu_resp == (n == lat), rq, 32'(cpu_resp), 32'(n == lat));
      chk(cpu_ready == (n > lat), "R7", 32'(cpu_ready), 32'(n > lat));
      if (n == lat && !we) chk(cpu_rdata == exp_d, rq, cpu_rdata, exp_d);
    end
    chk(wb_q.size() == int'(exp_wb), exp_wb ? rq : "R9",
        32'(wb_q.size()), 32'(exp_wb));
    if (exp_wb && wb_q.size() > 0) chk(wb_q[0] == wb_addr, rq, wb_q[0], wb_addr);
  endtask

  function automatic logic [31:0] mk(input int tg, input int idx, input int off);
    return {24'(tg), 4'(idx), 2'(off), 2'b00};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    wrap_up();
  end

  initial begin
    logic [31:0] lf;
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 16; s++) begin
        ref_v[w][s] = 0;
        ref_d[w][s] = 0;
        ref_tag[w][s] = '0;
      end
    for (int s = 0; s < 16; s++) ref_lru[s] = 0;
    rst_n = 1'b0;
    cpu_req = 1'b0;
    cpu_we = 1'b0;
    cpu_addr = '0;
    cpu_wdata = '0;
    cpu_be = '0;
    repeat (3) @(negedge clk);
    // R10 during reset
    chk(cpu_ready == 1'b1, "R10", 32'(cpu_ready), 32'd1);
    chk(cpu_resp == 1'b0, "R10", 32'(cpu_resp), 32'd0);
    chk(mem_req == 1'b0, "R10", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 after release
    chk(cpu_ready == 1'b1, "R10", 32'(cpu_ready), 32'd1);
    chk(cpu_resp == 1'b0, "R10", 32'(cpu_resp), 32'd0);
    chk(mem_req == 1'b0, "R10", 32'(mem_req), 32'd0);

    // R3 then R1 on the same line, way 0 filled first (R8)
    access(0, mk(1, 3, 2), 0, 0);
    access(0, mk(1, 3, 2), 0, 0);
    // R2 partial store then read back the merged word
    access(1, mk(1, 3, 1), 32'hdead_beef, 4'b0101);
    access(0, mk(1, 3, 1), 0, 0);
    // R4 store miss into the still invalid way 1 (R8)
    access(1, mk(2, 3, 0), 32'h1122_3344, 4'b1111);
    access(0, mk(2, 3, 0), 0, 0);
    // touch tag 1 so tag 2 becomes least recently used (R8)
    access(0, mk(1, 3, 0), 0, 0);
    // R5 evicts dirty tag 2, then R5 again evicts dirty tag 1
    access(0, mk(3, 3, 3), 0, 0);
    access(0, mk(2, 3, 0), 0, 0);
    // R9 tag 3 was only loaded: clean eviction, data of tag 1 survives
    access(0, mk(1, 3, 1), 0, 0);
    // R6 store miss that evicts a dirty line
    access(1, mk(4, 5, 0), 32'haaaa_5555, 4'b0011);
    access(1, mk(5, 5, 1), 32'h0f0f_f0f0, 4'b1100);
    access(1, mk(6, 5, 2), 32'h7777_8888, 4'b1000);
    access(0, mk(4, 5, 0), 0, 0);

    // mixed traffic over a few sets and tags
    lf = 32'h1ace_b00c;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      access(lf[0], mk(int'(lf[3:2]) + 1, int'(lf[5:4]), int'(lf[7:6])),
             {lf[15:0], lf[31:16]}, lf[11:8]);
    end

    wrap_up();
  end

endmodule